// File: doc/BRIEF.md
# SONET Parity Error Counter Bank

This block accumulates section, line and path parity violations (B1, B2 and B3) for a SONET receive path. Once per frame the block receives, for each of the three layers, the parity byte taken from the line and the parity byte recomputed locally. A frame-valid strobe qualifies them. The block compares the two bytes and adds the result to a running counter for that layer.

A single mode input sets how each comparison is weighed. In bit mode a frame adds the number of differing bit positions, from 0 to 8. In block mode a frame adds one when any bit differs. A snapshot strobe copies all three running counters into held output registers and restarts the running counters. The path-layer counts, running and held, stay at zero for as long as out-of-frame or loss of path pointer is present.

Top module: `bip_err_counter_bank`

## Requirements
- R1: When `rst_n` is low at a clock edge, all running and held counts become zero.
- R2: When `blk_mode` is 0 and `frame_vld` is 1, each layer's running count grows by the number of 1 bits in (received XOR computed).
- R3: When `blk_mode` is 1 and `frame_vld` is 1, each layer's running count grows by 1 if the two bytes differ in any bit, and by 0 otherwise.
- R4: Running counts saturate at the all-ones value of `CNT_W` bits and never wrap.
- R5: A `snap` pulse loads each held count with the running count value from before that edge. In the same edge the running count restarts at zero plus that cycle's increment.
- R6: While `oof` or `lopp` is 1, the path running count and the path held count (`b3_run`, `b3_held`) are zero at the next edge and stay zero. Path errors, frame strobes and `snap` have no effect on them during that time. B1 and B2 counting continues unaffected.
- R7: When `frame_vld` is 0, the received and computed bytes have no effect on any count.
- R8: Held counts change only on a `snap` edge or on path-defect clearing (R6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_mode | input | 1 | 0 = count errored bits, 1 = count errored blocks |
| frame_vld | input | 1 | Parity bytes valid this cycle (one per frame) |
| b1_rx | input | 8 | Received section parity byte |
| b1_calc | input | 8 | Recomputed section parity byte |
| b2_rx | input | 8 | Received line parity byte |
| b2_calc | input | 8 | Recomputed line parity byte |
| b3_rx | input | 8 | Received path parity byte |
| b3_calc | input | 8 | Recomputed path parity byte |
| oof | input | 1 | Out-of-frame status |
| lopp | input | 1 | Loss of path pointer status |
| snap | input | 1 | Snapshot strobe |
| b1_run | output | CNT_W | Section running count |
| b2_run | output | CNT_W | Line running count |
| b3_run | output | CNT_W | Path running count |
| b1_held | output | CNT_W | Section held count |
| b2_held | output | CNT_W | Line held count |
| b3_held | output | CNT_W | Path held count |

## Verification
A snapshot strobe can arrive on the same edge as a frame carrying errors. In that case the held value must be the pre-edge running count, and the new running count must equal only that frame's increment. The bench drives directed cases and random cases in which `snap` and `frame_vld` rise together. It also asserts path defects during strobes. A reference model recomputes every count from the rules, and the bench compares all six outputs after each edge.

// File: rtl/bip_cnt_pkg.sv
package bip_cnt_pkg;
    localparam int PAR_W   = 8;
    localparam int LAYERS  = 3;
    localparam int INC_W   = $clog2(PAR_W + 1);
    typedef enum logic {CNT_BITS = 1'b0, CNT_BLOCKS = 1'b1} cnt_mode_e;
endpackage

// File: rtl/bip_err_weigh.sv
// Turns one pair of parity bytes into the per-frame increment.
// Assumes the caller gates the result with the frame strobe.
module bip_err_weigh
    import bip_cnt_pkg::*;
(
    input  logic [PAR_W-1:0] rx_par,
    input  logic [PAR_W-1:0] calc_par,
    input  cnt_mode_e        mode,
    output logic [INC_W-1:0] incr
);
    logic [PAR_W-1:0] diff;
    logic [INC_W-1:0] pop;

    // Population count of the mismatch vector, then mode selection.
    always_comb begin
        diff = rx_par ^ calc_par;
        pop  = '0;
        for (int i = 0; i < PAR_W; i++) pop = pop + INC_W'(diff[i]);
        incr = (mode == CNT_BLOCKS) ? INC_W'(|diff) : pop;
    end
endmodule

// File: rtl/bip_sat_counter.sv
// Saturating running counter with snapshot register for one layer.
// Assumes incr is already zero outside frame cycles; hold forces both to zero.
module bip_sat_counter
    import bip_cnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] incr,
    input  logic             snap,
    input  logic             hold_zero,
    output logic [CNT_W-1:0] run_cnt,
    output logic [CNT_W-1:0] held_cnt
);
    localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] run_nxt;

    // Compute next running value: restart on snapshot, clamp at maximum.
    always_comb begin
        sum     = (snap ? '0 : {1'b0, run_cnt}) + (CNT_W+1)'(incr);
        run_nxt = (sum > MAXV) ? MAXV[CNT_W-1:0] : sum[CNT_W-1:0];
    end

    // Register running and held counts.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_zero) begin
            run_cnt  <= '0;
            held_cnt <= '0;
        end else begin
            run_cnt <= run_nxt;
            if (snap) held_cnt <= run_cnt;
        end
    end
endmodule

// File: rtl/bip_err_counter_bank.sv
// Three-layer parity error counter bank (section, line, path).
// Assumes frame_vld pulses once per frame; path layer is zeroed on defects.
module bip_err_counter_bank
    import bip_cnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_mode,
    input  logic             frame_vld,
    input  logic [7:0]       b1_rx,
    input  logic [7:0]       b1_calc,
    input  logic [7:0]       b2_rx,
    input  logic [7:0]       b2_calc,
    input  logic [7:0]       b3_rx,
    input  logic [7:0]       b3_calc,
    input  logic             oof,
    input  logic             lopp,
    input  logic             snap,
    output logic [CNT_W-1:0] b1_run,
    output logic [CNT_W-1:0] b2_run,
    output logic [CNT_W-1:0] b3_run,
    output logic [CNT_W-1:0] b1_held,
    output logic [CNT_W-1:0] b2_held,
    output logic [CNT_W-1:0] b3_held
);
    logic [PAR_W-1:0] rx_v   [LAYERS];
    logic [PAR_W-1:0] calc_v [LAYERS];
    logic [CNT_W-1:0] run_v  [LAYERS];
    logic [CNT_W-1:0] held_v [LAYERS];
    logic             path_def;

    // Gather layer inputs into arrays and flag the path defect.
    always_comb begin
        rx_v[0] = b1_rx;   calc_v[0] = b1_calc;
        rx_v[1] = b2_rx;   calc_v[1] = b2_calc;
        rx_v[2] = b3_rx;   calc_v[2] = b3_calc;
        path_def = oof | lopp;
    end

    for (genvar g = 0; g < LAYERS; g++) begin : g_layer
        logic [INC_W-1:0] w_incr;
        logic [INC_W-1:0] incr_q;
        bip_err_weigh u_weigh (
            .rx_par   (rx_v[g]),
            .calc_par (calc_v[g]),
            .mode     (cnt_mode_e'(blk_mode)),
            .incr     (w_incr)
        );
        // Gate the increment with the frame strobe.
        always_comb incr_q = frame_vld ? w_incr : '0;
        bip_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .incr      (incr_q),
            .snap      (snap),
            .hold_zero ((g == LAYERS-1) ? path_def : 1'b0),
            .run_cnt   (run_v[g]),
            .held_cnt  (held_v[g])
        );
    end

    // Drive output ports from the layer arrays.
    always_comb begin
        b1_run = run_v[0];  b1_held = held_v[0];
        b2_run = run_v[1];  b2_held = held_v[1];
        b3_run = run_v[2];  b3_held = held_v[2];
    end
endmodule

// File: rtl/bip_err_counter_bank_chk.sv
// Checker for the counter bank; bound to the top module below.
module bip_err_counter_bank_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_vld,
    input logic             oof,
    input logic             lopp,
    input logic             snap,
    input logic [CNT_W-1:0] b1_run,
    input logic [CNT_W-1:0] b3_run,
    input logic [CNT_W-1:0] b1_held,
    input logic [CNT_W-1:0] b3_held
);
    // R1: reset clears counts
    a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> (b1_run == '0 && b3_held == '0));
    // R6: path counts forced to zero under defect
    a_r6_path_zero: assert property (@(posedge clk) disable iff (!rst_n) (oof || lopp) |=> (b3_run == '0 && b3_held == '0));
    // R7: no frame, no snapshot: running count unchanged
    a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n) (!frame_vld && !snap) |=> $stable(b1_run));
    // R8: held count stable without snapshot
    a_r8_held_stable: assert property (@(posedge clk) disable iff (!rst_n) !snap |=> $stable(b1_held));
    // R5: held takes the prior running value
    a_r5_snap_copy: assert property (@(posedge clk) disable iff (!rst_n) snap |=> (b1_held == $past(b1_run)));
    // R4: never wraps to a smaller value without snapshot
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n) !snap |=> (b1_run >= $past(b1_run)));
endmodule

bind bip_err_counter_bank bip_err_counter_bank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .oof(oof), .lopp(lopp),
    .snap(snap), .b1_run(b1_run), .b3_run(b3_run), .b1_held(b1_held), .b3_held(b3_held)
);

// File: tb/tb_bip_err_counter_bank.sv
module tb_bip_err_counter_bank;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int MAXC = (1 << W) - 1;

    logic clk = 0, rst_n = 0, blk_mode = 0, frame_vld = 0, oof = 0, lopp = 0, snap = 0;
    logic [7:0] b1_rx = 0, b1_calc = 0, b2_rx = 0, b2_calc = 0, b3_rx = 0, b3_calc = 0;
    logic [W-1:0] b1_run, b2_run, b3_run, b1_held, b2_held, b3_held;

    int compared = 0, mismatched = 0;
    int m_run[3], m_held[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    bip_err_counter_bank #(.CNT_W(W)) dut (.*);

    function automatic int weigh(input logic [7:0] a, input logic [7:0] b, input logic blk);
        int c = 0;
        for (int i = 0; i < 8; i++) c += int'(a[i] ^ b[i]);
        return blk ? int'(c != 0) : c;
    endfunction

    function automatic int sat(input int v);
        return (v > MAXC) ? MAXC : v;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, b1_run, m_run[0]);  chk(req, b2_run, m_run[1]);  chk(req, b3_run, m_run[2]);
        chk(req, b1_held, m_held[0]); chk(req, b2_held, m_held[1]); chk(req, b3_held, m_held[2]);
    endtask

    // Apply one cycle of stimulus, update the model, compare after the edge.
    task automatic step(input string req);
        int inc[3];
        inc[0] = frame_vld ? weigh(b1_rx, b1_calc, blk_mode) : 0;
        inc[1] = frame_vld ? weigh(b2_rx, b2_calc, blk_mode) : 0;
        inc[2] = frame_vld ? weigh(b3_rx, b3_calc, blk_mode) : 0;
        for (int l = 0; l < 3; l++) begin
            if (!rst_n || (l == 2 && (oof || lopp))) begin
                m_run[l] = 0; m_held[l] = 0;
            end else begin
                if (snap) m_held[l] = m_run[l];
                m_run[l] = sat((snap ? 0 : m_run[l]) + inc[l]);
            end
        end
        @(posedge clk); #1;
        check_all(req);
    endtask

    task automatic setb(input logic [7:0] a1, c1, a2, c2, a3, c3);
        b1_rx = a1; b1_calc = c1; b2_rx = a2; b2_calc = c2; b3_rx = a3; b3_calc = c3;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int l = 0; l < 3; l++) begin m_run[l] = 0; m_held[l] = 0; end
        #1;
        step("R1"); step("R1");
        rst_n = 1;
        // R2 bit mode
        frame_vld = 1; setb(8'hFF, 8'h00, 8'h0F, 8'h00, 8'h01, 8'h00); step("R2");
        setb(8'hAA, 8'hAA, 8'h81, 8'h00, 8'h3C, 8'h00); step("R2");
        // R7 bytes ignored without strobe
        frame_vld = 0; setb(8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00); step("R7"); step("R7");
        // R3 block mode
        blk_mode = 1; frame_vld = 1; step("R3");
        setb(8'h12, 8'h12, 8'h80, 8'h00, 8'h00, 8'h00); step("R3");
        // R5 snapshot coinciding with errored frame
        blk_mode = 0; setb(8'h07, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00); snap = 1; step("R5");
        snap = 0; frame_vld = 0; step("R8"); step("R8");
        // R6 path defect zeros path counts, errors and snapshot ignored
        frame_vld = 1; oof = 1; setb(8'h01, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h00); step("R6");
        snap = 1; step("R6"); snap = 0;
        oof = 0; lopp = 1; step("R6"); lopp = 0; step("R6");
        // R4 saturation: drive many full-error frames
        blk_mode = 0; setb(8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
        for (int i = 0; i < 8200; i++) step("R4");
        chk("R4", b1_run, MAXC);
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            blk_mode  = $urandom % 2;
            frame_vld = ($urandom % 3) != 0;
            snap      = ($urandom % 8) == 0;
            oof       = ($urandom % 20) == 0;
            lopp      = ($urandom % 25) == 0;
            rst_n     = ($urandom % 500) != 0;
            setb($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
            step("R5");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule